// File: doc/BRIEF.md
# Diagonal Fault Binning and Spare Budget Check

This block walks a rectangular fault map of ROWS x COLS processing cells, one cell per accepted input bit, in row-major order (row 0 first, column 0 first within a row). A bit value of 1 marks the cell as faulty. Each cell belongs to one diagonal of the array, namely the line of cells that are linked corner to corner from (r,c) to (r+1,c+1). The block keeps one fault tally per diagonal. When the final cell has been taken it raises a one-cycle completion pulse and presents three results: a mask with one bit per diagonal that holds at least one fault, the number of such diagonals, and a verdict. The verdict says that the array cannot be repaired, because more diagonals need removal than the supplied budget of redundant columns allows.

A host pulses `start`, streams the map through `bit_valid` and `bit_fault`, and reads the results once `done` has pulsed. The results stay in place until the next `start`. A finite-state machine has four states. IDLE waits after reset. SCAN accepts bits. FIN lasts one cycle and drives `done`. HOLD keeps the results. The transitions are LAUNCH (any state to SCAN on `start`), LAST_CELL (SCAN to FIN on the final accepted bit) and REPORT (FIN to HOLD, unconditional).

Top module: `diag_fault_scan`

## Requirements
- R1: After reset, `done`, `unrepairable`, `diag_count` and every bit of `diag_mask` are 0.
- R2: A fault at zero-based row r and column c sets bit c + (ROWS-1-r) of `diag_mask`. Bit 0 is the bottom-left corner cell and bit ROWS+COLS-2 is the top-right corner cell.
- R3: `diag_count` equals the number of diagonals that received at least one fault in the current scan.
- R4: `unrepairable` is 1 exactly when `diag_count` is strictly greater than `col_budget`. The comparison follows `col_budget` in the same cycle.
- R5: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepts the ROWS*COLS-th valid bit, and `done` is low at every other time.
- R6: A cycle with `bit_valid` low neither advances the scan position nor records its `bit_fault` value.
- R7: After `done`, the mask, count and verdict keep their values until the next `start`, whatever `bit_valid` and `bit_fault` do.
- R8: `start` clears all tallies on the next edge, including in the middle of a scan, and restarts the scan at row 0, column 0. A bit presented in the same cycle as `start` is discarded.
- R9: Before the first `start` after reset, valid bits are ignored and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears tallies and begins a scan |
| bit_valid | input | 1 | `bit_fault` carries the next cell |
| bit_fault | input | 1 | 1 = current cell is faulty |
| col_budget | input | $clog2(ROWS+COLS) | Number of redundant columns available |
| done | output | 1 | One-cycle pulse after the last cell |
| diag_mask | output | ROWS+COLS-1 | Bit d set when diagonal d holds a fault |
| diag_count | output | $clog2(ROWS+COLS) | Number of set bits in `diag_mask` |
| unrepairable | output | 1 | `diag_count` exceeds `col_budget` |

## Verification
Single-fault maps at the two extreme corners and at the origin check the index mapping at both ends of the mask and in its middle. An all-faulty map fills every diagonal, and sweeping the budget around the diagonal count tells a strict comparison apart from an inclusive one. Random sparse and dense maps streamed with random idle gaps, whose idle cycles carry random fault bits, show whether idle cycles move the scan position or leak into the tallies. Extra valid bits after completion, a restart in the middle of a scan and bits sent before any start check that results are held and that restart clears the state.

// File: rtl/diag_scan_pkg.sv
package diag_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2,
        ST_HOLD = 2'd3
    } scan_state_e;

    function automatic int min_dim(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/diag_scan_pos.sv
module diag_scan_pos #(
    parameter int ROWS = 4,
    parameter int COLS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            step,
    output logic [$clog2(ROWS+COLS-1)-1:0]  diag_idx,
    output logic                            last_cell
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int DW = $clog2(ROWS+COLS-1);

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          row_end;
    logic          col_end;

    assign row_end   = (row_q == RW'(ROWS-1));
    assign col_end   = (col_q == CW'(COLS-1));
    assign last_cell = row_end && col_end;

    // cells sharing (col - row) lie on one diagonal; offset keeps it non-negative
    assign diag_idx = DW'(col_q) + DW'(ROWS-1) - DW'(row_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (clr) begin
            row_q <= '0;
            col_q <= '0;
        end else if (step) begin
            if (col_end) begin
                col_q <= '0;
                row_q <= row_end ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/diag_bin_bank.sv
module diag_bin_bank #(
    parameter int NDIAG = 11,
    parameter int LIMIT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      hit,
    input  logic [$clog2(NDIAG)-1:0]  idx,
    output logic [NDIAG-1:0]          nz_mask
);
    localparam int TW = $clog2(LIMIT+1);
    localparam int DW = $clog2(NDIAG);

    for (genvar d = 0; d < NDIAG; d++) begin : g_bin
        logic [TW-1:0] tally_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tally_q <= '0;
            end else if (clr) begin
                tally_q <= '0;
            end else if (hit && (idx == DW'(d)) && (tally_q != TW'(LIMIT))) begin
                tally_q <= tally_q + 1'b1;
            end
        end

        assign nz_mask[d] = (tally_q != '0);
    end

endmodule

// File: rtl/diag_verdict.sv
module diag_verdict #(
    parameter int NDIAG = 11,
    parameter int BW    = 4
) (
    input  logic [NDIAG-1:0] nz_mask,
    input  logic [BW-1:0]    budget,
    output logic [BW-1:0]    nz_count,
    output logic             over_budget
);
    always_comb begin
        nz_count = '0;
        for (int d = 0; d < NDIAG; d++) begin
            nz_count = nz_count + BW'(nz_mask[d]);
        end
    end

    assign over_budget = (nz_count > budget);

endmodule

// File: rtl/diag_fault_scan.sv
module diag_fault_scan
    import diag_scan_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          bit_valid,
    input  logic                          bit_fault,
    input  logic [$clog2(ROWS+COLS)-1:0]  col_budget,
    output logic                          done,
    output logic [ROWS+COLS-2:0]          diag_mask,
    output logic [$clog2(ROWS+COLS)-1:0]  diag_count,
    output logic                          unrepairable
);
    localparam int NDIAG = ROWS + COLS - 1;
    localparam int DW    = $clog2(NDIAG);
    localparam int BW    = $clog2(ROWS + COLS);
    localparam int LIMIT = min_dim(ROWS, COLS);

    scan_state_e state_q, state_d;
    logic        step;
    logic        last_cell;
    logic [DW-1:0] diag_idx;

    assign step = (state_q == ST_SCAN) && bit_valid && !start;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SCAN: if (step && last_cell) state_d = ST_FIN;
                ST_FIN:  state_d = ST_HOLD;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        done = 1'b0;
        unique case (state_q)
            ST_FIN:  done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    diag_scan_pos #(.ROWS(ROWS), .COLS(COLS)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .step      (step),
        .diag_idx  (diag_idx),
        .last_cell (last_cell)
    );

    diag_bin_bank #(.NDIAG(NDIAG), .LIMIT(LIMIT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .hit     (step && bit_fault),
        .idx     (diag_idx),
        .nz_mask (diag_mask)
    );

    diag_verdict #(.NDIAG(NDIAG), .BW(BW)) u_verdict (
        .nz_mask     (diag_mask),
        .budget      (col_budget),
        .nz_count    (diag_count),
        .over_budget (unrepairable)
    );

endmodule

// File: rtl/diag_fault_scan_chk.sv
module diag_fault_scan_chk #(
    parameter int NDIAG = 11,
    parameter int BW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [NDIAG-1:0] diag_mask,
    input logic [BW-1:0]    diag_count,
    input logic             unrepairable,
    input logic             in_idle,
    input logic             in_hold
);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diag_count == BW'($countones(diag_mask)));

    // R4
    verdict_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unrepairable |-> (diag_count != '0));

    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (diag_mask == '0) && !done);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !start) |=> $stable(diag_mask));

    // R9
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !start) |=> (diag_mask == '0));

    // R2
    mask_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (($past(diag_mask) & ~diag_mask) == '0));

endmodule

bind diag_fault_scan diag_fault_scan_chk #(.NDIAG(NDIAG), .BW(BW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (done),
    .diag_mask    (diag_mask),
    .diag_count   (diag_count),
    .unrepairable (unrepairable),
    .in_idle      (state_q == diag_scan_pkg::ST_IDLE),
    .in_hold      (state_q == diag_scan_pkg::ST_HOLD)
);

// File: tb/test_diag_fault_scan.sv
module test_diag_fault_scan;
    localparam int ROWS  = 4;
    localparam int COLS  = 8;
    localparam int NC    = ROWS * COLS;
    localparam int NDIAG = ROWS + COLS - 1;
    localparam int BW    = $clog2(ROWS + COLS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_fault = 1'b0;
    logic [BW-1:0] col_budget = '0;
    logic done;
    logic [NDIAG-1:0] diag_mask;
    logic [BW-1:0] diag_count;
    logic unrepairable;

    int n_checks = 0;
    int n_fails  = 0;
    int early_done = 0;

    always #10 clk = ~clk;

    diag_fault_scan #(.ROWS(ROWS), .COLS(COLS)) i_diag_fault_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
        .bit_fault(bit_fault), .col_budget(col_budget), .done(done),
        .diag_mask(diag_mask), .diag_count(diag_count), .unrepairable(unrepairable)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NDIAG-1:0] exp_mask(input logic [NC-1:0] map);
        logic [NDIAG-1:0] m = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (map[r*COLS + c]) m[c + ROWS - 1 - r] = 1'b1;
        return m;
    endfunction

    function automatic logic [NC-1:0] rand_map(input int pct);
        logic [NC-1:0] m = '0;
        for (int k = 0; k < NC; k++) m[k] = ($urandom_range(99) < pct);
        return m;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input logic [NC-1:0] map, input int gap_pct, input int upto);
        for (int k = 0; k < upto; k++) begin
            while ($urandom_range(99) < gap_pct) begin
                bit_valid = 1'b0;
                bit_fault = 1'($urandom_range(1));
                @(negedge clk);
                if (done) early_done++;
            end
            bit_valid = 1'b1;
            bit_fault = map[k];
            @(negedge clk);
            if (done && k < NC - 1) early_done++;
        end
        bit_valid = 1'b0;
        bit_fault = 1'b0;
    endtask

    task automatic full_scan(input logic [NC-1:0] map, input int gap_pct, input logic [BW-1:0] bud);
        logic [NDIAG-1:0] em;
        int ec;
        col_budget = bud;
        early_done = 0;
        pulse_start();
        feed(map, gap_pct, NC);
        em = exp_mask(map);
        ec = $countones(em);
        check("R5 done after last cell", 64'(done), 64'd1);
        check("R5 no early done", 64'(early_done), 64'd0);
        check("R2 mask", 64'(diag_mask), 64'(em));
        check("R3 count", 64'(diag_count), 64'(ec));
        check("R4 verdict", 64'(unrepairable), 64'(ec > int'(bud)));
        @(negedge clk);
        check("R5 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic run_all();
        logic [NC-1:0] map;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", 64'(done), 64'd0);
        check("R1 mask", 64'(diag_mask), 64'd0);
        check("R1 count", 64'(diag_count), 64'd0);
        check("R1 verdict", 64'(unrepairable), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 bits before any start are ignored
        early_done = 0;
        feed({NC{1'b1}}, 0, NC);
        @(negedge clk);
        check("R9 mask unchanged", 64'(diag_mask), 64'd0);
        check("R9 no done", 64'(early_done) | 64'(done), 64'd0);

        // directed corners (R2)
        full_scan('0, 0, '0);
        map = '0; map[(ROWS-1)*COLS] = 1'b1;  full_scan(map, 0, '0);
        map = '0; map[COLS-1] = 1'b1;         full_scan(map, 0, '0);
        map = '0; map[0] = 1'b1;              full_scan(map, 30, '0);
        // all faulty, budget boundaries (R4)
        full_scan({NC{1'b1}}, 0, BW'(NDIAG - 1));
        full_scan({NC{1'b1}}, 0, BW'(NDIAG));
        col_budget = BW'(NDIAG - 1); #1;
        check("R4 live budget below", 64'(unrepairable), 64'd1);
        col_budget = BW'(NDIAG); #1;
        check("R4 live budget equal", 64'(unrepairable), 64'd0);

        // R7 hold after done
        map = rand_map(15);
        full_scan(map, 10, BW'(3));
        for (int k = 0; k < 12; k++) begin
            bit_valid = 1'b1; bit_fault = 1'b1;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        check("R7 mask held", 64'(diag_mask), 64'(exp_mask(map)));
        check("R7 no done while held", 64'(done), 64'd0);

        // R8 restart mid-scan, bit in start cycle discarded
        col_budget = '0;
        pulse_start();
        feed({NC{1'b1}}, 0, NC / 2);
        bit_valid = 1'b1; bit_fault = 1'b1;
        pulse_start();
        bit_valid = 1'b0;
        check("R8 cleared after start", 64'(diag_mask), 64'd0);
        check("R8 count cleared", 64'(diag_count), 64'd0);
        map = '0; map[NC-1] = 1'b1;
        early_done = 0;
        feed(map, 0, NC);
        check("R8 fresh scan done", 64'(done), 64'd1);
        check("R8 only new faults", 64'(diag_mask), 64'(exp_mask(map)));
        @(negedge clk);

        // random maps with idle gaps (R6, R2, R3, R4)
        for (int t = 0; t < 40; t++) begin
            map = rand_map((t % 2 == 0) ? 8 : 50);
            full_scan(map, 25, BW'($urandom_range(NDIAG)));
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule